// File: doc/BRIEF.md
# Fault Status Blink-Code Generator

This block turns a set of fault flags into a repeating on/off code on an active-low open-drain status pin. A fixed priority picks the most important active fault. A segment sequencer then plays that fault's code as a list of low and high intervals, and wraps back to the start when the list ends. Each fault type has its own code, so an LED placed on the pin identifies the fault by eye.

Every interval is counted in pulses of a slow timebase input. One pulse lasts about 83 ms, and the caller generates it. The output is a registered "pull the pin low" enable that drives the pad's open-drain transistor. With no fault the enable is off, so the external pull-up holds the pin high.

Top module: `fault_code_blinker`

## Requirements
- R1: Out of reset, and on every cycle after a clock edge at which no fault flag was set, `pin_low_en_o` is 0 (pin released, reads high).
- R2: On the cycle after any clock edge at which `flt_lock_i` was set, `pin_low_en_o` is 1. A lock fault keeps the pin low for as long as it lasts.
- R3: The overcurrent code repeats 8 ticks released, then 8 ticks low.
- R4: The thermal-shutdown code repeats 8 low, 2 released, 1 low, 2 released, 1 low, 2 released (ticks).
- R5: The supply/system-error code repeats 1 low, 1 released, 1 low, 13 released (ticks).
- R6: The overvoltage code repeats 2 ticks released, then 2 ticks low.
- R7: The low-demand code repeats 3 released, 1 low, 4 released, 8 low (ticks).
- R8: When several flags are set, only one code plays. The priority from highest to lowest is lock, overcurrent, thermal, system error, overvoltage, low demand.
- R9: When the selected fault changes at a clock edge, the new code starts at its first interval on the next cycle. The old code is abandoned part-way through.
- R10: `pin_low_en_o` is a register output. It changes only after a clock edge at which `tick_i` was high or at which the flag set differed from the edge before. An interval of N ticks ends on its Nth tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one cycle wide, about 83 ms apart |
| flt_lock_i | input | 1 | Rotor lock fault flag |
| flt_overcur_i | input | 1 | Overcurrent fault flag |
| flt_thermal_i | input | 1 | Thermal shutdown flag |
| flt_sysfail_i | input | 1 | Supply/regulator undervoltage (system error) flag |
| flt_overvolt_i | input | 1 | Supply overvoltage flag |
| flt_lowdem_i | input | 1 | Demand below on threshold flag |
| pin_low_en_o | output | 1 | 1 = pull the status pin low |

## Verification
The checker watches four things on every cycle. An idle flag set always releases the pin. A lock always pulls the pin low. A newly selected overcurrent or thermal code opens with its first interval. The output never moves unless a tick arrived or the flag set changed. The exact interval lengths, the wrap-around of each code and the full priority order under overlapping flags are sequence properties spanning many ticks. Only the bench shows these, by comparing the pin each cycle against a reference model that expands every code into one level per tick and runs it across single faults, stacked faults, mid-code switches and uneven tick spacing.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

    localparam int NUM_FLAGS = 6;
    localparam int SEG_W     = 3;
    localparam int DUR_W     = 4;

    // interval lengths in timebase ticks (about 83 ms each)
    localparam int TK_1  = 1;
    localparam int TK_2  = 2;
    localparam int TK_3  = 3;
    localparam int TK_4  = 4;
    localparam int TK_8  = 8;
    localparam int TK_13 = 13;

    // code value = flag index + 1; lower value wins
    typedef enum logic [2:0] {
        CODE_IDLE     = 3'd0,
        CODE_LOCK     = 3'd1,
        CODE_OVERCUR  = 3'd2,
        CODE_THERMAL  = 3'd3,
        CODE_SYSFAIL  = 3'd4,
        CODE_OVERVOLT = 3'd5,
        CODE_LOWDEM   = 3'd6
    } code_e;

    typedef struct packed {
        logic             low;
        logic [DUR_W-1:0] dur;
        logic             last;
    } seg_t;

    typedef struct packed {
        code_e            code;
        logic [SEG_W-1:0] seg;
        logic [DUR_W-1:0] cnt;
    } seq_state_t;

    function automatic seg_t mk_seg(logic low, int dur, logic last);
        seg_t r;
        r.low  = low;
        r.dur  = DUR_W'(dur);
        r.last = last;
        return r;
    endfunction

    function automatic seg_t seg_lookup(code_e c, logic [SEG_W-1:0] s);
        seg_t r;
        r = mk_seg(1'b0, TK_1, 1'b1);
        unique case (c)
            CODE_LOCK: r = mk_seg(1'b1, TK_1, 1'b1);
            CODE_OVERCUR: begin
                case (s)
                    3'd0:    r = mk_seg(1'b0, TK_8, 1'b0);
                    3'd1:    r = mk_seg(1'b1, TK_8, 1'b1);
                    default: r = mk_seg(1'b0, TK_1, 1'b1);
                endcase
            end
            CODE_THERMAL: begin
                case (s)
                    3'd0:    r = mk_seg(1'b1, TK_8, 1'b0);
                    3'd1:    r = mk_seg(1'b0, TK_2, 1'b0);
                    3'd2:    r = mk_seg(1'b1, TK_1, 1'b0);
                    3'd3:    r = mk_seg(1'b0, TK_2, 1'b0);
                    3'd4:    r = mk_seg(1'b1, TK_1, 1'b0);
                    3'd5:    r = mk_seg(1'b0, TK_2, 1'b1);
                    default: r = mk_seg(1'b0, TK_1, 1'b1);
                endcase
            end
            CODE_SYSFAIL: begin
                case (s)
                    3'd0:    r = mk_seg(1'b1, TK_1, 1'b0);
                    3'd1:    r = mk_seg(1'b0, TK_1, 1'b0);
                    3'd2:    r = mk_seg(1'b1, TK_1, 1'b0);
                    3'd3:    r = mk_seg(1'b0, TK_13, 1'b1);
                    default: r = mk_seg(1'b0, TK_1, 1'b1);
                endcase
            end
            CODE_OVERVOLT: begin
                case (s)
                    3'd0:    r = mk_seg(1'b0, TK_2, 1'b0);
                    3'd1:    r = mk_seg(1'b1, TK_2, 1'b1);
                    default: r = mk_seg(1'b0, TK_1, 1'b1);
                endcase
            end
            CODE_LOWDEM: begin
                case (s)
                    3'd0:    r = mk_seg(1'b0, TK_3, 1'b0);
                    3'd1:    r = mk_seg(1'b1, TK_1, 1'b0);
                    3'd2:    r = mk_seg(1'b0, TK_4, 1'b0);
                    3'd3:    r = mk_seg(1'b1, TK_8, 1'b1);
                    default: r = mk_seg(1'b0, TK_1, 1'b1);
                endcase
            end
            default: r = mk_seg(1'b0, TK_1, 1'b1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcb_prio_sel.sv
module fcb_prio_sel
    import fcb_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic [N-1:0] flags_i,
    output code_e        sel_o
);
    // index 0 is the most important flag; scan from the bottom up so it wins
    always_comb begin
        sel_o = CODE_IDLE;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags_i[i]) begin
                sel_o = code_e'(3'(i + 1));
            end
        end
    end
endmodule

// File: rtl/fcb_pattern_rom.sv
module fcb_pattern_rom
    import fcb_pkg::*;
(
    input  code_e            code_i,
    input  logic [SEG_W-1:0] seg_i,
    output logic             low_o,
    output logic [DUR_W-1:0] dur_o,
    output logic             last_o
);
    seg_t entry;

    always_comb begin
        entry  = seg_lookup(code_i, seg_i);
        low_o  = entry.low;
        dur_o  = entry.dur;
        last_o = entry.last;
    end
endmodule

// File: rtl/fcb_seq_core.sv
module fcb_seq_core
    import fcb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  code_e            sel_code_i,
    output code_e            cur_code_o,
    output logic [SEG_W-1:0] cur_seg_o,
    input  logic [DUR_W-1:0] cur_dur_i,
    input  logic             cur_last_i,
    output code_e            nxt_code_o,
    output logic [SEG_W-1:0] nxt_seg_o,
    input  logic             nxt_low_i,
    output logic             pin_low_o
);
    seq_state_t st_d, st_q;
    logic       low_d, low_q;
    logic [DUR_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + (DUR_W+1)'(1);
        if (sel_code_i != st_q.code) begin
            st_d.code = sel_code_i;
            st_d.seg  = '0;
            st_d.cnt  = '0;
        end else if (tick_i) begin
            if (cnt_inc >= {1'b0, cur_dur_i}) begin
                st_d.cnt = '0;
                st_d.seg = cur_last_i ? '0 : st_q.seg + SEG_W'(1);
            end else begin
                st_d.cnt = cnt_inc[DUR_W-1:0];
            end
        end
        low_d = nxt_low_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= '{code: CODE_IDLE, seg: '0, cnt: '0};
            low_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            low_q <= low_d;
        end
    end

    assign cur_code_o = st_q.code;
    assign cur_seg_o  = st_q.seg;
    assign nxt_code_o = st_d.code;
    assign nxt_seg_o  = st_d.seg;
    assign pin_low_o  = low_q;
endmodule

// File: rtl/fault_code_blinker.sv
module fault_code_blinker
    import fcb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic flt_lock_i,
    input  logic flt_overcur_i,
    input  logic flt_thermal_i,
    input  logic flt_sysfail_i,
    input  logic flt_overvolt_i,
    input  logic flt_lowdem_i,
    output logic pin_low_en_o
);
    logic [NUM_FLAGS-1:0] flags;
    code_e                sel_code;
    code_e                cur_code, nxt_code;
    logic [SEG_W-1:0]     cur_seg, nxt_seg;
    logic [DUR_W-1:0]     cur_dur, nxt_dur_unused;
    logic                 cur_last, cur_low_unused, nxt_low, nxt_last_unused;

    // bit position is priority rank (0 = highest)
    assign flags = {flt_lowdem_i, flt_overvolt_i, flt_sysfail_i,
                    flt_thermal_i, flt_overcur_i, flt_lock_i};

    fcb_prio_sel #(.N(NUM_FLAGS)) u_prio (
        .flags_i (flags),
        .sel_o   (sel_code)
    );

    // interval length / wrap of the segment now playing
    fcb_pattern_rom u_rom_cur (
        .code_i (cur_code),
        .seg_i  (cur_seg),
        .low_o  (cur_low_unused),
        .dur_o  (cur_dur),
        .last_o (cur_last)
    );

    // pin level of the segment entered at this edge
    fcb_pattern_rom u_rom_nxt (
        .code_i (nxt_code),
        .seg_i  (nxt_seg),
        .low_o  (nxt_low),
        .dur_o  (nxt_dur_unused),
        .last_o (nxt_last_unused)
    );

    fcb_seq_core u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .sel_code_i (sel_code),
        .cur_code_o (cur_code),
        .cur_seg_o  (cur_seg),
        .cur_dur_i  (cur_dur),
        .cur_last_i (cur_last),
        .nxt_code_o (nxt_code),
        .nxt_seg_o  (nxt_seg),
        .nxt_low_i  (nxt_low),
        .pin_low_o  (pin_low_en_o)
    );
endmodule

// File: rtl/fcb_chk.sv
module fcb_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic flt_lock_i,
    input logic flt_overcur_i,
    input logic flt_thermal_i,
    input logic flt_sysfail_i,
    input logic flt_overvolt_i,
    input logic flt_lowdem_i,
    input logic pin_low_en_o
);
    logic [5:0] fl;
    logic       armed_q;

    assign fl = {flt_lowdem_i, flt_overvolt_i, flt_sysfail_i,
                 flt_thermal_i, flt_overcur_i, flt_lock_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fl == 6'd0) |=> !pin_low_en_o);

    p_lock_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_lock_i |=> pin_low_en_o);

    // R9: a freshly selected overcurrent code opens released
    p_ocp_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $rose(flt_overcur_i) && !flt_lock_i) |=> !pin_low_en_o);

    // R4 with R9: a freshly selected thermal code opens low
    p_thermal_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $rose(flt_thermal_i) && !flt_lock_i && !flt_overcur_i)
        |=> pin_low_en_o);

    p_quiet_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !tick_i && $stable(fl)) |=> $stable(pin_low_en_o));
endmodule

bind fault_code_blinker fcb_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .flt_lock_i     (flt_lock_i),
    .flt_overcur_i  (flt_overcur_i),
    .flt_thermal_i  (flt_thermal_i),
    .flt_sysfail_i  (flt_sysfail_i),
    .flt_overvolt_i (flt_overvolt_i),
    .flt_lowdem_i   (flt_lowdem_i),
    .pin_low_en_o   (pin_low_en_o)
);

// File: tb/fault_code_blinker_tb_top.sv
`timescale 1ns/1ps
module fault_code_blinker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] flags = 6'd0;   // [0]=lock ... [5]=low demand
    logic       pin_low;

    int errors = 0;
    int checks = 0;
    int tick_gap = 3;
    int tick_cnt = 0;
    bit done = 1'b0;

    // reference: every code expanded to one level per tick (1 = low)
    bit pat[7][$];
    int m_code = 0;
    int m_pos  = 0;
    int since_change = 99;

    always #2 clk = ~clk;

    fault_code_blinker dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .tick_i         (tick),
        .flt_lock_i     (flags[0]),
        .flt_overcur_i  (flags[1]),
        .flt_thermal_i  (flags[2]),
        .flt_sysfail_i  (flags[3]),
        .flt_overvolt_i (flags[4]),
        .flt_lowdem_i   (flags[5]),
        .pin_low_en_o   (pin_low)
    );

    task automatic add(int c, bit lvl, int n);
        for (int k = 0; k < n; k++) pat[c].push_back(lvl);
    endtask

    function automatic int pick(logic [5:0] f);
        for (int i = 0; i < 6; i++) if (f[i]) return i + 1;
        return 0;
    endfunction

    function automatic string req_of(int c, logic [5:0] f, int sc);
        string s;
        case (c)
            0: s = "R1"; 1: s = "R2"; 2: s = "R3"; 3: s = "R4";
            4: s = "R5"; 5: s = "R6"; default: s = "R7";
        endcase
        if ($countones(f) > 1) s = {s, "/R8"};
        if (sc <= 1) s = {s, "/R9"};
        return {s, "/R10"};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        add(0, 1'b0, 1);
        add(1, 1'b1, 1);
        add(2, 1'b0, 8); add(2, 1'b1, 8);
        add(3, 1'b1, 8); add(3, 1'b0, 2); add(3, 1'b1, 1);
        add(3, 1'b0, 2); add(3, 1'b1, 1); add(3, 1'b0, 2);
        add(4, 1'b1, 1); add(4, 1'b0, 1); add(4, 1'b1, 1); add(4, 1'b0, 13);
        add(5, 1'b0, 2); add(5, 1'b1, 2);
        add(6, 1'b0, 3); add(6, 1'b1, 1); add(6, 1'b0, 4); add(6, 1'b1, 8);
    end

    // reference model update at the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_pos = 0; since_change = 99;
        end else begin
            if (pick(flags) != m_code) begin
                m_code = pick(flags); m_pos = 0; since_change = 0;
            end else begin
                since_change++;
                if (tick) m_pos = (m_pos + 1) % pat[m_code].size();
            end
        end
    end

    // compare away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(pin_low === pat[m_code][m_pos], req_of(m_code, flags, since_change),
                  int'(pin_low), int'(pat[m_code][m_pos]));
        end
    end

    // timebase
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_gap) begin tick <= 1'b1; tick_cnt <= 0; end
        else begin tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
    end

    task automatic run(logic [5:0] f, int cycles);
        @(negedge clk);
        flags = f;
        repeat (cycles - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check(pin_low === 1'b0, "R1 reset", int'(pin_low), 0);
        @(negedge clk) rst_n = 1'b1;
        run(6'b000000, 20);                      // R1 idle
        run(6'b000001, 40);                      // R2 lock
        run(6'b000010, 110);                     // R3
        run(6'b000100, 110);                     // R4
        run(6'b001000, 110);                     // R5
        run(6'b010000, 40);                      // R6
        run(6'b100000, 110);                     // R7
        tick_gap = 5;
        run(6'b111110, 90);                      // R8: overcurrent wins
        run(6'b111100, 90);                      // R8/R9: thermal restarts
        run(6'b111000, 90);                      // R8: system error
        run(6'b110000, 30);                      // R8: overvoltage
        run(6'b111111, 30);                      // R8: lock over all
        tick_gap = 1;
        run(6'b000010, 13);                      // R9 mid-code switch
        run(6'b100000, 7);
        run(6'b000100, 11);
        run(6'b000000, 10);                      // R1 release
        tick_gap = 2;
        run(6'b001000, 60);                      // R5 + R10 spacing
        // R8 explicit: lock set with other flags pulls low the next cycle
        @(negedge clk) flags = 6'b010101;
        @(negedge clk);
        check(pin_low === 1'b1, "R8 lock priority", int'(pin_low), 1);
        run(6'b000000, 5);
        check(pin_low === 1'b0, "R1 idle after faults", int'(pin_low), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule